// File: doc/BRIEF.md
# Shared Address Translation Unit

This block turns a packed partitioned-global shared pointer into a flat system virtual address for shared loads and stores. Software first programs a per-thread table of base addresses, one entry per command, and a register that holds how many threads are running. After that, every access presents a 64-bit shared pointer and a small signed displacement. The block looks up the base address of the thread named in the pointer, then adds the pointer's local virtual-address field and the sign-extended displacement. The displacement lets code reach one member of a structure without doing extra pointer arithmetic.

Requests are accepted on every clock cycle. Each one produces exactly one response, two cycles later. A pointer whose thread number is not below the programmed thread count does not produce an address. Instead it returns a response with the error flag set.

Top module: `sat_xlate`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_err` and `rsp_addr` are 0. The thread count is 0, so any request made before the count is programmed responds with an error.
- R2: Pointer layout: thread number in bits [63:48], phase in bits [47:32] and local virtual address in bits [31:0]. The phase field has no effect on the result.
- R3: For an in-range request, `rsp_addr` = base[thread] + zero-extended virtual address, taken modulo 2^48. For example, base 0xFF0B00000000 for thread 1 with address field 0x3F00 gives 0xFF0B00003F00.
- R4: `req_disp` is a 12-bit two's-complement value. It is sign-extended and added to the translated address: 0x7FF adds 2047, 0x800 subtracts 2048 and 0xFFF subtracts 1.
- R5: Every cycle with `req_valid` high produces one cycle of `rsp_valid` exactly two clock edges later. Back-to-back requests give back-to-back responses, and idle cycles give no response.
- R6: A request whose thread field is greater than or equal to the thread count responds with `rsp_valid`=1, `rsp_err`=1 and `rsp_addr`=0.
- R7: A set-base command (`cfg_base_we`) writes only the entry selected by `cfg_base_idx`. All other entries keep their values. A request presented on the cycle after the write sees the new value.
- R8: A set-threads command (`cfg_thr_we`) loads the count, clamped to a maximum of 64. A request presented in the same cycle as the write is judged against the old count. A request presented in the following cycle is judged against the new one.
- R9: While `rsp_valid` is 0, `rsp_err` and `rsp_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_we | input | 1 | Set-base command strobe |
| cfg_base_idx | input | 6 | Table entry (thread number) to write |
| cfg_base_data | input | 48 | Base address written into the entry |
| cfg_thr_we | input | 1 | Set-threads command strobe |
| cfg_thr_data | input | 7 | Number of running threads (clamped to 64) |
| req_valid | input | 1 | Translation request strobe |
| req_ptr | input | 64 | Packed shared pointer |
| req_disp | input | 12 | Signed displacement added after translation |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_addr | output | 48 | Translated system virtual address |
| rsp_err | output | 1 | Thread out of range; no address produced |

## Verification
A request driven before clock edge k is captured at edge k: the table read, the range compare and the operand registers all happen there. The sum becomes visible on the outputs after edge k+1. The bench drives inputs on falling edges and keeps a two-deep queue of expected responses. At each falling edge it compares the outputs with the entry queued two falling edges earlier, so idle cycles are checked as well as responses. The same-cycle cases for the count and table writes are scheduled against this two-edge timing, so that the old-value and new-value cases each fall on a known cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int PTR_W = 64;
  localparam int THR_W = 16;
  localparam int PH_W  = 16;
  localparam int VA_W  = 32;

  typedef struct packed {
    logic [THR_W-1:0] thread;
    logic [PH_W-1:0]  phase;
    logic [VA_W-1:0]  va;
  } shptr_t;
endpackage

// File: rtl/sat_base_table.sv
module sat_base_table #(
  parameter int DEPTH = 64,
  parameter int W     = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // synchronous read, single write port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sat_thread_limit.sv
module sat_thread_limit #(
  parameter int DEPTH = 64,
  parameter int TW    = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_data,
  input  logic [TW-1:0] thread,
  output logic          in_range
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_we) cnt_q <= (int'(cnt_data) > DEPTH) ? CW'(DEPTH) : cnt_data;
  end

  assign in_range = thread < TW'(cnt_q);
endmodule

// File: rtl/sat_sum_stage.sv
module sat_sum_stage #(
  parameter int W      = 48,
  parameter int VA_W   = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_ok,
  input  logic [W-1:0]      base,
  input  logic [VA_W-1:0]   va,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic              out_err,
  output logic [W-1:0]      out_addr
);
  logic [W-1:0] disp_ext;
  logic [W-1:0] sum;

  assign disp_ext = {{(W-DISP_W){disp[DISP_W-1]}}, disp};
  assign sum      = base + W'(va) + disp_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & ~in_ok;
      out_addr  <= (in_valid && in_ok) ? sum : '0;
    end
  end
endmodule

// File: rtl/sat_xlate.sv
module sat_xlate
  import sat_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int BASE_W = 48,
  parameter int DISP_W = 12,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_base_we,
  input  logic [IDX_W-1:0]  cfg_base_idx,
  input  logic [BASE_W-1:0] cfg_base_data,
  input  logic              cfg_thr_we,
  input  logic [CNT_W-1:0]  cfg_thr_data,
  input  logic              req_valid,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [DISP_W-1:0] req_disp,
  output logic              rsp_valid,
  output logic [BASE_W-1:0] rsp_addr,
  output logic              rsp_err
);
  shptr_t            ptr;
  logic              in_range;
  logic [BASE_W-1:0] base_rd;
  logic              s1_valid;
  logic              s1_ok;
  logic [VA_W-1:0]   s1_va;
  logic [DISP_W-1:0] s1_disp;

  assign ptr = shptr_t'(req_ptr);

  sat_base_table #(.DEPTH(DEPTH), .W(BASE_W), .AW(IDX_W)) u_table (
    .clk   (clk),
    .we    (cfg_base_we),
    .waddr (cfg_base_idx),
    .wdata (cfg_base_data),
    .raddr (ptr.thread[IDX_W-1:0]),
    .rdata (base_rd)
  );

  sat_thread_limit #(.DEPTH(DEPTH), .TW(THR_W), .CW(CNT_W)) u_limit (
    .clk      (clk),
    .rst      (rst),
    .cnt_we   (cfg_thr_we),
    .cnt_data (cfg_thr_data),
    .thread   (ptr.thread),
    .in_range (in_range)
  );

  // stage 1: operands captured alongside the table read
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
    s1_ok   <= in_range;
    s1_va   <= ptr.va;
    s1_disp <= req_disp;
  end

  sat_sum_stage #(.W(BASE_W), .VA_W(VA_W), .DISP_W(DISP_W)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .in_ok     (s1_ok),
    .base      (base_rd),
    .va        (s1_va),
    .disp      (s1_disp),
    .out_valid (rsp_valid),
    .out_err   (rsp_err),
    .out_addr  (rsp_addr)
  );
endmodule

// File: rtl/sat_xlate_chk.sv
module sat_xlate_chk #(
  parameter int DEPTH  = 64,
  parameter int BASE_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [63:0]       req_ptr,
  input logic              rsp_valid,
  input logic [BASE_W-1:0] rsp_addr,
  input logic              rsp_err
);
  logic        v1, v2;
  logic [15:0] t1, t2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      t1 <= '0;
      t2 <= '0;
    end else begin
      v1 <= req_valid;
      v2 <= v1;
      t1 <= req_ptr[63:48];
      t2 <= t1;
    end
  end

  AST_TWO_CYCLE_RSP: assert property (@(posedge clk) disable iff (rst) rsp_valid == v2); // R5
  AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (rst) rsp_err |-> rsp_valid); // R6
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (rst) rsp_err |-> rsp_addr == '0); // R6
  AST_OK_THREAD_IN_TABLE: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_err) |-> (t2 < 16'(DEPTH))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !rsp_valid |-> (rsp_addr == '0 && !rsp_err)); // R9
endmodule

bind sat_xlate sat_xlate_chk #(.DEPTH(DEPTH), .BASE_W(BASE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ptr   (req_ptr),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_err   (rsp_err)
);

// File: tb/sim_sat_xlate.sv
module sim_sat_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_base_we;
  logic [5:0]  cfg_base_idx;
  logic [47:0] cfg_base_data;
  logic        cfg_thr_we;
  logic [6:0]  cfg_thr_data;
  logic        req_valid;
  logic [63:0] req_ptr;
  logic [11:0] req_disp;
  logic        rsp_valid;
  logic [47:0] rsp_addr;
  logic        rsp_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [47:0] base_m [64];
  int          cnt_m = 0;

  logic        p1_v = 0, p2_v = 0, p1_e = 0, p2_e = 0;
  logic [47:0] p1_a = 0, p2_a = 0;
  string       p1_tag = "R9 idle", p2_tag = "R9 idle";

  always #4 clk = ~clk;

  sat_xlate u0 (
    .clk(clk), .rst(rst),
    .cfg_base_we(cfg_base_we), .cfg_base_idx(cfg_base_idx), .cfg_base_data(cfg_base_data),
    .cfg_thr_we(cfg_thr_we), .cfg_thr_data(cfg_thr_data),
    .req_valid(req_valid), .req_ptr(req_ptr), .req_disp(req_disp),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  function automatic logic [63:0] mk(input logic [15:0] thr, input logic [15:0] ph, input logic [31:0] va);
    return {thr, ph, va};
  endfunction

  task automatic cyc(input logic v, input logic [63:0] p, input logic [11:0] d,
                     input logic bwe, input logic [5:0] bi, input logic [47:0] bd,
                     input logic twe, input logic [6:0] td, input string tag);
    logic        e_err;
    logic [47:0] e_addr;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== p2_v || rsp_err !== p2_e || rsp_addr !== p2_a) begin
      n_fail++;
      $display("FAIL %s: got v=%0b e=%0b a=%h, expected v=%0b e=%0b a=%h",
               p2_tag, rsp_valid, rsp_err, rsp_addr, p2_v, p2_e, p2_a);
    end
    p2_v = p1_v; p2_e = p1_e; p2_a = p1_a; p2_tag = p1_tag;
    e_err  = v && (int'(p[63:48]) >= cnt_m);
    e_addr = (v && !e_err) ? (base_m[p[53:48]] + {16'h0, p[31:0]} + {{36{d[11]}}, d}) : 48'h0;
    p1_v = v; p1_e = e_err; p1_a = e_addr; p1_tag = tag;
    req_valid = v; req_ptr = p; req_disp = d;
    cfg_base_we = bwe; cfg_base_idx = bi; cfg_base_data = bd;
    cfg_thr_we = twe; cfg_thr_data = td;
    if (bwe) base_m[bi] = bd;
    if (twe) cnt_m = (int'(td) > 64) ? 64 : int'(td);
  endtask

  task automatic rq(input logic [63:0] p, input logic [11:0] d, input string tag);
    cyc(1'b1, p, d, 1'b0, 6'd0, 48'h0, 1'b0, 7'd0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 64'h0, 12'h0, 1'b0, 6'd0, 48'h0, 1'b0, 7'd0, tag);
  endtask

  task automatic wb(input logic [5:0] i, input logic [47:0] bd);
    cyc(1'b0, 64'h0, 12'h0, 1'b1, i, bd, 1'b0, 7'd0, "R7 table write cycle");
  endtask

  task automatic wt(input logic [6:0] td);
    cyc(1'b0, 64'h0, 12'h0, 1'b0, 6'd0, 48'h0, 1'b1, td, "R8 count write cycle");
  endtask

  initial begin
    rst = 1'b1;
    req_valid = 0; req_ptr = 0; req_disp = 0;
    cfg_base_we = 0; cfg_base_idx = 0; cfg_base_data = 0;
    cfg_thr_we = 0; cfg_thr_data = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_addr !== 48'h0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%0b e=%0b a=%h, expected v=0 e=0 a=0", rsp_valid, rsp_err, rsp_addr);
    end
    rst = 1'b0;
    rq(mk(16'd0, 16'd0, 32'h100), 12'h0, "R1 count is zero after reset");
    idle("R9 idle");
    for (int i = 0; i < 64; i++) wb(6'(i), 48'(i) * 48'h0000_1001_0000 + 48'h40);
    wt(7'd64);
    for (int i = 0; i < 64; i++)
      rq(mk(16'(i), 16'(i * 5), 32'(i) * 32'h0101_0103), 12'(i * 37), "R3 full table sweep");
    idle("R5 gap"); idle("R5 gap"); idle("R5 gap");
    wb(6'd1, 48'hFF0B_0000_0000);
    rq(mk(16'd1, 16'd0, 32'h3F00), 12'h0, "R3 worked example");
    rq(mk(16'd2, 16'd0, 32'h1000), 12'h7FF, "R4 largest positive displacement");
    rq(mk(16'd2, 16'd0, 32'h1000), 12'h800, "R4 most negative displacement");
    rq(mk(16'd2, 16'd0, 32'h1000), 12'hFFF, "R4 displacement minus one");
    wb(6'd63, 48'hFFFF_FFFF_F000);
    rq(mk(16'd63, 16'd0, 32'h2000), 12'h0, "R3 wraps modulo 2^48");
    rq(mk(16'd5, 16'h0000, 32'hABCD_0123), 12'h011, "R2 phase zero");
    rq(mk(16'd5, 16'hFFFF, 32'hABCD_0123), 12'h011, "R2 phase all ones");
    wt(7'd5);
    for (int t = 0; t < 10; t++) rq(mk(16'(t), 16'd3, 32'h55), 12'h2, "R6 thread against count 5");
    rq(mk(16'hFFFF, 16'd0, 32'h55), 12'h0, "R6 largest thread field");
    cyc(1'b1, mk(16'd7, 16'd0, 32'h10), 12'h0, 1'b0, 6'd0, 48'h0, 1'b1, 7'd10, "R8 same-cycle write uses old count");
    rq(mk(16'd7, 16'd0, 32'h10), 12'h0, "R8 next cycle uses new count");
    wt(7'd100);
    rq(mk(16'd64, 16'd0, 32'h10), 12'h0, "R8 count clamped to 64");
    rq(mk(16'd63, 16'd0, 32'h10), 12'h0, "R8 thread 63 with clamped count");
    wb(6'd7, 48'h1234_5678_9ABC);
    rq(mk(16'd7, 16'd0, 32'h4), 12'h0, "R7 written entry read next cycle");
    rq(mk(16'd6, 16'd0, 32'h4), 12'h0, "R7 neighbour below unchanged");
    rq(mk(16'd8, 16'd0, 32'h4), 12'h0, "R7 neighbour above unchanged");
    idle("R9 idle"); idle("R9 idle"); idle("R5 drain");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog expired: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule